// File: doc/BRIEF.md
# Validation Event Counter Bank

This block holds four free-running up-counters that a validation environment uses to trigger events inside a processor at a chosen moment. A host reaches the counters through a coprocessor-style access port. A 3-bit selector picks the counter, and a write flag chooses between a load and a read. Each counter has its own run enable. While that enable is high, the counter advances by one on every clock edge. When the counter rolls over from all ones to zero, it emits a single-cycle pulse on its event line. The four event lines are a reset request, an interrupt request, a fast interrupt request and an external debug request.

Every access passes through a permission check. The check uses the processor's privilege level, the security world, a user/non-secure enable input, and a lock input that blocks writes from secure privileged code. Each access ends in one of four ways: it completes, it is silently ignored, it is flagged as an undefined-instruction access, or it is flagged as unpredictable. The response (read data and flags) is registered and appears in the cycle after the access is presented. Raising the actual exceptions is left to the surrounding logic.

Top module: `valev_counter_bank`

## Requirements
- R1: Selector 1 addresses the reset counter (event bit 0), selector 2 the interrupt counter (bit 1), selector 3 the fast interrupt counter (bit 2) and selector 7 the debug counter (bit 3).
- R2: A permitted write to selector 1, 2 or 3 loads the write data into that counter at the access edge. A permitted read of selector 1, 2 or 3 returns the counter value on `rsp_rdata` in the following cycle. Every other response carries zero read data.
- R3: An access with selector 0, 4, 5 or 6 changes no counter and raises neither flag.
- R4: A counter whose run enable is high increments by one per clock. A counter whose run enable is low holds its value.
- R5: A running counter that steps from all ones to zero raises its event bit for exactly one cycle, in the cycle after that step. It then keeps counting from zero while enabled.
- R6: The debug counter is 7 bits wide. A write keeps only bits 6:0 of the write data.
- R7: A permitted read of selector 7 returns zero, raises `rsp_unpred` and changes no state.
- R8: Secure privileged accesses are always permitted, except a write while `wr_lock` is high. That write raises `rsp_undef` and leaves the counter unchanged.
- R9: Secure user accesses and all non-secure accesses raise `rsp_undef` and have no effect when `user_ns_en` is 0. They are permitted when it is 1, whatever `wr_lock` is.
- R10: After reset, all counters are zero and all outputs are low.
- R11: A permitted write takes priority over the increment of a running counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Counter selector |
| acc_wdata | input | DATA_W | Write data |
| acc_priv | input | 1 | Privileged mode (1) or user mode (0) |
| acc_secure | input | 1 | Secure world (1) or non-secure world (0) |
| user_ns_en | input | 1 | Enables secure user and non-secure access |
| wr_lock | input | 1 | Blocks secure privileged writes |
| run_en | input | 4 | Per-counter run enable, bit index as in R1 |
| rsp_rdata | output | DATA_W | Read data, one cycle after the access |
| rsp_undef | output | 1 | Access was undefined, one cycle after the access |
| rsp_unpred | output | 1 | Access was unpredictable, one cycle after the access |
| evt_pulse | output | 4 | Wrap event pulses, bit index as in R1 |

## Verification
The assertions check the access matrix on every cycle. They confirm that the two flags never rise together and that a locked secure write or a disabled user/non-secure access always yields `rsp_undef`. They also confirm that a bad selector stays silent, that an unpredictable read returns zero, and that an event pulse lasts one cycle and only follows a cycle with its enable high. Only the bench scenarios can show that data reached the right counter, that a counter wraps after the expected number of cycles, that the debug counter masks its load, and that a write wins over a concurrent increment.

// File: rtl/valev_pkg.sv
package valev_pkg;

   localparam int NUM_CTR = 4;

   typedef enum logic [1:0] {
      EV_RESET = 2'd0,
      EV_IRQ   = 2'd1,
      EV_FIQ   = 2'd2,
      EV_DEBUG = 2'd3
   } ev_idx_e;

   typedef struct packed {
      logic    hit;
      logic    readable;
      ev_idx_e idx;
   } sel_dec_t;

   function automatic sel_dec_t decode_sel(input logic [2:0] sel);
      sel_dec_t d;
      d = '{hit: 1'b0, readable: 1'b0, idx: EV_RESET};
      unique case (sel)
         3'd1: d = '{hit: 1'b1, readable: 1'b1, idx: EV_RESET};
         3'd2: d = '{hit: 1'b1, readable: 1'b1, idx: EV_IRQ};
         3'd3: d = '{hit: 1'b1, readable: 1'b1, idx: EV_FIQ};
         3'd7: d = '{hit: 1'b1, readable: 1'b0, idx: EV_DEBUG};
         default: d = '{hit: 1'b0, readable: 1'b0, idx: EV_RESET};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/valev_access_check.sv
module valev_access_check
   import valev_pkg::*;
(
   input  logic       acc_valid,
   input  logic       acc_write,
   input  logic [2:0] acc_sel,
   input  logic       acc_priv,
   input  logic       acc_secure,
   input  logic       user_ns_en,
   input  logic       wr_lock,
   output logic       do_load,
   output logic       do_read,
   output logic       is_undef,
   output logic       is_unpred,
   output ev_idx_e    tgt_idx
);

   sel_dec_t dec;
   logic     blocked;
   logic     granted;

   always_comb begin
      dec     = decode_sel(acc_sel);
      tgt_idx = dec.idx;
      if (acc_secure && acc_priv)
         blocked = acc_write && wr_lock;
      else
         blocked = !user_ns_en;
      granted   = acc_valid && dec.hit && !blocked;
      is_undef  = acc_valid && dec.hit && blocked;
      do_load   = granted && acc_write;
      do_read   = granted && !acc_write && dec.readable;
      is_unpred = granted && !acc_write && !dec.readable;
   end

endmodule

// File: rtl/valev_counter.sv
module valev_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         wrap_evt
);

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         wrap_evt <= 1'b0;
      end else begin
         wrap_evt <= run && !load && (count == TOP);
         if (load)
            count <= load_val;
         else if (run)
            count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/valev_counter_bank.sv
module valev_counter_bank
   import valev_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int MAIN_W = 32,
   parameter int DBG_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_sel,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_priv,
   input  logic              acc_secure,
   input  logic              user_ns_en,
   input  logic              wr_lock,
   input  logic [3:0]        run_en,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_undef,
   output logic              rsp_unpred,
   output logic [3:0]        evt_pulse
);

   if (MAIN_W < 1 || MAIN_W > DATA_W) begin : g_bad_main
      $error("MAIN_W must lie in 1..DATA_W");
   end
   if (DBG_W < 1 || DBG_W > DATA_W) begin : g_bad_dbg
      $error("DBG_W must lie in 1..DATA_W");
   end

   logic    do_load, do_read, is_undef, is_unpred;
   ev_idx_e tgt_idx;
   logic [NUM_CTR-1:0][DATA_W-1:0] cnt_ext;

   valev_access_check u_check (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_sel   (acc_sel),
      .acc_priv  (acc_priv),
      .acc_secure(acc_secure),
      .user_ns_en(user_ns_en),
      .wr_lock   (wr_lock),
      .do_load   (do_load),
      .do_read   (do_read),
      .is_undef  (is_undef),
      .is_unpred (is_unpred),
      .tgt_idx   (tgt_idx)
   );

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      localparam int W = (i == int'(EV_DEBUG)) ? DBG_W : MAIN_W;
      logic [W-1:0] cnt_w;

      valev_counter #(.W(W)) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_en[i]),
         .load    (do_load && (tgt_idx == ev_idx_e'(i))),
         .load_val(acc_wdata[W-1:0]),
         .count   (cnt_w),
         .wrap_evt(evt_pulse[i])
      );

      assign cnt_ext[i] = DATA_W'(cnt_w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata  <= '0;
         rsp_undef  <= 1'b0;
         rsp_unpred <= 1'b0;
      end else begin
         rsp_rdata  <= do_read ? cnt_ext[tgt_idx] : '0;
         rsp_undef  <= is_undef;
         rsp_unpred <= is_unpred;
      end
   end

endmodule

// File: rtl/valev_counter_bank_chk.sv
module valev_counter_bank_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [2:0]        acc_sel,
   input logic              acc_priv,
   input logic              acc_secure,
   input logic              user_ns_en,
   input logic              wr_lock,
   input logic [3:0]        run_en,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_undef,
   input logic              rsp_unpred,
   input logic [3:0]        evt_pulse
);

   logic sel_known;
   assign sel_known = (acc_sel == 3'd1) || (acc_sel == 3'd2) ||
                      (acc_sel == 3'd3) || (acc_sel == 3'd7);

   a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_undef && rsp_unpred));

   a_r3_bad_sel_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sel_known) |=> (!rsp_undef && !rsp_unpred && rsp_rdata == '0));

   a_r7_unpred_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_unpred |-> (rsp_rdata == '0));

   a_r8_lock_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_secure && acc_priv && wr_lock && sel_known)
      |=> rsp_undef);

   a_r9_disabled_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(acc_secure && acc_priv) && !user_ns_en && sel_known)
      |=> (rsp_undef && rsp_rdata == '0));

   for (genvar i = 0; i < 4; i++) begin : g_evt
      a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[i] |=> !evt_pulse[i]);
      a_r4_pulse_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[i] |-> $past(run_en[i]));
   end

endmodule

bind valev_counter_bank valev_counter_bank_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/valev_counter_bank_test.sv
module valev_counter_bank_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0]  acc_sel = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_priv = 1'b0, acc_secure = 1'b0, user_ns_en = 1'b0, wr_lock = 1'b0;
   logic [3:0]  run_en = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_undef, rsp_unpred;
   logic [3:0]  evt_pulse;

   int n_chk = 0, n_fail = 0;
   int pcnt [4] = '{0, 0, 0, 0};
   int base [4];
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   valev_counter_bank uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
      .acc_secure(acc_secure), .user_ns_en(user_ns_en), .wr_lock(wr_lock),
      .run_en(run_en), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
      .rsp_unpred(rsp_unpred), .evt_pulse(evt_pulse)
   );

   always @(negedge clk)
      if (rst_n)
         for (int i = 0; i < 4; i++) if (evt_pulse[i]) pcnt[i]++;

   // {write, sel, wdata, priv, secure, v, lock, exp_undef, exp_unpred, exp_rdata}
   localparam logic [73:0] VEC [0:NVEC-1] = '{
      {1'b1, 3'd1, 32'h1111_1111, 4'b1100, 2'b00, 32'h0},         // R2 secure priv write
      {1'b0, 3'd1, 32'h0,         4'b1100, 2'b00, 32'h1111_1111}, // R2 read back
      {1'b1, 3'd2, 32'h0000_0022, 4'b0100, 2'b10, 32'h0},         // R9 secure user, V=0
      {1'b0, 3'd2, 32'h0,         4'b1100, 2'b00, 32'h0},         // R9 no load happened
      {1'b1, 3'd2, 32'h0000_2222, 4'b1010, 2'b00, 32'h0},         // R9 non-secure priv, V=1
      {1'b0, 3'd2, 32'h0,         4'b0010, 2'b00, 32'h0000_2222}, // R9 non-secure user read
      {1'b1, 3'd3, 32'h0000_0033, 4'b1101, 2'b10, 32'h0},         // R8 locked write
      {1'b0, 3'd3, 32'h0,         4'b1101, 2'b00, 32'h0},         // R8 read allowed, no load
      {1'b1, 3'd5, 32'h0000_DEAD, 4'b1100, 2'b00, 32'h0},         // R3 unknown selector write
      {1'b0, 3'd5, 32'h0,         4'b1100, 2'b00, 32'h0},         // R3 unknown selector read
      {1'b1, 3'd7, 32'hFFFF_FF85, 4'b1100, 2'b00, 32'h0},         // R1 debug counter write
      {1'b0, 3'd7, 32'h0,         4'b1100, 2'b01, 32'h0},         // R7 debug read unpredictable
      {1'b0, 3'd1, 32'h0,         4'b1000, 2'b10, 32'h0},         // R9 non-secure priv, V=0
      {1'b1, 3'd0, 32'h0000_0001, 4'b1100, 2'b00, 32'h0},         // R3 selector 0 write
      {1'b0, 3'd1, 32'h0,         4'b0011, 2'b00, 32'h1111_1111}, // R3 counter 1 untouched
      {1'b1, 3'd1, 32'h0000_0077, 4'b0011, 2'b00, 32'h0},         // R9 lock ignored non-secure
      {1'b0, 3'd1, 32'h0,         4'b1100, 2'b00, 32'h0000_0077}  // R9 load landed
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called right after a falling edge; returns at the next falling edge
   // with the registered response visible.
   task automatic access(input logic wr, input logic [2:0] sel, input logic [31:0] wd,
                         input logic [3:0] mode);
      acc_valid = 1'b1; acc_write = wr; acc_sel = sel; acc_wdata = wd;
      {acc_priv, acc_secure, user_ns_en, wr_lock} = mode;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_sel = '0; acc_wdata = '0;
   endtask

   task automatic snap();
      for (int i = 0; i < 4; i++) base[i] = pcnt[i];
   endtask

   task automatic chk_evt(input string req, input logic [3:0] exp);
      logic [3:0] d;
      for (int i = 0; i < 4; i++) d[i] = (pcnt[i] - base[i]) != 0;
      n_chk++;
      if (d !== exp || (pcnt[0]-base[0]) > 1 || (pcnt[1]-base[1]) > 1 ||
          (pcnt[2]-base[2]) > 1 || (pcnt[3]-base[3]) > 1) begin
         n_fail++;
         $display("FAIL %s: actual pulses %0d%0d%0d%0d expected mask %b",
                  req, pcnt[3]-base[3], pcnt[2]-base[2], pcnt[1]-base[1], pcnt[0]-base[0], exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 outputs", {rsp_rdata[27:0], rsp_undef, rsp_unpred, |evt_pulse, 1'b0},
          32'h0);
      for (int s = 1; s <= 3; s++) begin
         access(1'b0, 3'(s), 32'h0, 4'b1100);
         chk("R10 counter cleared", rsp_rdata, 32'h0);
      end

      // Table walk: access rules R2 R3 R7 R8 R9
      for (int k = 0; k < NVEC; k++) begin
         logic [73:0] v;
         v = VEC[k];
         access(v[73], v[72:70], v[69:38], v[37:34]);
         n_chk++;
         if (rsp_undef !== v[33] || rsp_unpred !== v[32] || rsp_rdata !== v[31:0]) begin
            n_fail++;
            $display("FAIL R2/R3/R7/R8/R9 vector %0d: actual %b%b %h expected %b%b %h",
                     k, rsp_undef, rsp_unpred, rsp_rdata, v[33], v[32], v[31:0]);
         end
      end

      // R4: ten cycles of counting, then hold
      access(1'b1, 3'd1, 32'd100, 4'b1100);
      run_en[0] = 1'b1;
      repeat (10) @(negedge clk);
      run_en[0] = 1'b0;
      access(1'b0, 3'd1, 32'h0, 4'b1100);
      chk("R4 count after 10 cycles", rsp_rdata, 32'd110);
      repeat (5) @(negedge clk);
      access(1'b0, 3'd1, 32'h0, 4'b1100);
      chk("R4 held while disabled", rsp_rdata, 32'd110);

      // R5 / R1: fast interrupt counter wraps, keeps counting from zero
      access(1'b1, 3'd3, 32'hFFFF_FFFD, 4'b1100);
      snap();
      run_en[2] = 1'b1;
      repeat (6) @(negedge clk);
      run_en[2] = 1'b0;
      chk_evt("R5 fast interrupt wrap", 4'b0100);
      access(1'b0, 3'd3, 32'h0, 4'b1100);
      chk("R5 continues after wrap", rsp_rdata, 32'd3);

      // R1: interrupt and reset counters map to bits 1 and 0
      access(1'b1, 3'd2, 32'hFFFF_FFFF, 4'b1100);
      snap();
      run_en[1] = 1'b1;
      repeat (2) @(negedge clk);
      run_en[1] = 1'b0;
      chk_evt("R1 interrupt event bit", 4'b0010);
      access(1'b1, 3'd1, 32'hFFFF_FFFF, 4'b1100);
      snap();
      run_en[0] = 1'b1;
      repeat (2) @(negedge clk);
      run_en[0] = 1'b0;
      chk_evt("R1 reset event bit", 4'b0001);

      // R6: debug counter keeps bits 6:0 only -> 0x7E wraps on second step
      access(1'b1, 3'd7, 32'hFFFF_FF7E, 4'b1100);
      snap();
      run_en[3] = 1'b1;
      @(negedge clk);
      chk_evt("R6 no pulse after first step", 4'b0000);
      @(negedge clk);
      @(negedge clk);
      run_en[3] = 1'b0;
      chk_evt("R6 debug wrap at 7 bits", 4'b1000);

      // R11: write while running wins over increment
      access(1'b1, 3'd1, 32'd7, 4'b1100);
      run_en[0] = 1'b1;
      access(1'b1, 3'd1, 32'd500, 4'b1100);
      run_en[0] = 1'b0;
      access(1'b0, 3'd1, 32'h0, 4'b1100);
      chk("R11 load beats increment", rsp_rdata, 32'd500);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule